// File: doc/BRIEF.md
# Activation Propagation String

This block models the activation network of a linear string of processing-element slots. Each slot carries a match tag and a destination tag. On an activate strobe the block registers a new activation vector. It builds that vector either from the tags directly or by sending a one-bit signal along the string from the matched slots. The signal moves in a chosen direction and may activate neighbours, the first destination it reaches, the run up to the next match, or everything up to the end of the string.

Between every pair of adjacent slots there is a link bistable. An open link stops the signal, which divides the string into segments that software defines. The links are loaded either from a vector or by a single command that cuts the string into equal segments whose length is a power of two. Two ports sit at the string ends and stand in for the neighbours of the outermost slots. A signal can be injected at these ports, and the signal leaving the string can be sensed there.

Top module: `act_spread`

## Requirements
- R1: Reset clears the activation vector to zero and closes every link (all link bits 0).
- R2: The activation vector changes only at a clock edge where `fire` is 1, and then takes the value computed from the inputs present at that edge. Without `fire` it holds.
- R3: Mode 0 loads the match tags into the activation vector. Mode 1 loads their complement.
- R4: Mode 2 (neighbour) activates the slot next to each matched slot on the side given by `dir`. `dir`=1 moves toward higher indices; slot 0 is the left end. The end slot that has no upstream neighbour takes the injected port value: `lp_in` when `dir`=1, `rp_in` when `dir`=0.
- R5: Mode 3 (remote) sends a signal from each matched slot, and from the injecting port, in direction `dir`. The signal passes slots whose destination tag is 0. It activates the first slot whose destination tag is 1 and stops there.
- R6: Mode 4 (between) treats matches along the direction of travel alternately as openers and closers. It activates every slot after an opener up to and including the next match. When `incl_src`=1 the opener is also activated.
- R7: Mode 5 (to end) activates every slot downstream of any match, up to the string end. When `incl_src`=1 the matched slot itself is also activated.
- R8: Link j lies between slot j and slot j+1; 1 means open. An open link blocks the signal in modes 2 to 5, in both directions. This includes a neighbour that lies across it.
- R9: `seg_cmd` loads link j as open exactly when the low `seg_lg` bits of j+1 are all zero. This gives segments of 2^`seg_lg` slots. `seg_cmd` takes priority over `link_wr`, which loads `link_wdata`.
- R10: The port at the downstream end (`rp_out` when `dir`=1, `lp_out` when `dir`=0) shows the signal leaving the last slot, combinationally. The other port is 0. Both ports are 0 in modes 0, 1, 6 and 7.
- R11: Modes 6 and 7 load an all-zero activation vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_tag | input | N | Match tag per slot |
| d_tag | input | N | Destination tag per slot |
| mode | input | 3 | Activation option code |
| dir | input | 1 | 1 = signal travels toward higher index, 0 = toward lower |
| incl_src | input | 1 | Include the source slot in modes 4 and 5 |
| lp_in | input | 1 | Signal injected at the left end |
| rp_in | input | 1 | Signal injected at the right end |
| fire | input | 1 | Activate strobe |
| link_wr | input | 1 | Load the link register from `link_wdata` |
| link_wdata | input | N-1 | Link values, 1 = open |
| seg_cmd | input | 1 | Load equal power-of-two segments |
| seg_lg | input | clog2(N)+1 | Segment length exponent |
| act | output | N | Registered activation vector |
| lp_out | output | 1 | Signal sensed leaving the left end |
| rp_out | output | 1 | Signal sensed leaving the right end |

## Verification
The bench builds the block with N = 8. At that size every expected vector can be worked out by hand. It also makes `seg_lg` values 0 to 3 reachable, which covers single-slot segments, segments of two and four slots, and one whole-string segment. Each propagation mode is run in both directions, with and without injection at the ports. Links are placed so that a signal, a neighbour and an unclosed between-run each meet an open link or the string end.

// File: rtl/act_spread.sv
module act_spread #(
  parameter int N = 16,
  localparam int LGW = $clog2(N) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   m_tag,
  input  logic [N-1:0]   d_tag,
  input  logic [2:0]     mode,
  input  logic           dir,
  input  logic           incl_src,
  input  logic           lp_in,
  input  logic           rp_in,
  input  logic           fire,
  input  logic           link_wr,
  input  logic [N-2:0]   link_wdata,
  input  logic           seg_cmd,
  input  logic [LGW-1:0] seg_lg,
  output logic [N-1:0]   act,
  output logic           lp_out,
  output logic           rp_out
);
  localparam logic [2:0] MD_MATCH = 3'd0;
  localparam logic [2:0] MD_MISS  = 3'd1;
  localparam logic [2:0] MD_NEIGH = 3'd2;
  localparam logic [2:0] MD_REMOTE = 3'd3;
  localparam logic [2:0] MD_BETW  = 3'd4;
  localparam logic [2:0] MD_END   = 3'd5;

  logic [N-2:0] link_q, seg_pat, lk_r;
  logic [N-1:0] m_r, d_r, blk, a_r, a_nxt;
  logic [31:0]  msk;
  logic         inj, tail, c;

  assign msk = (32'd1 << seg_lg) - 32'd1;
  assign inj = dir ? lp_in : rp_in;
  assign blk = {lk_r, 1'b0};

  always_comb begin
    for (int j = 0; j < N - 1; j++) begin
      seg_pat[j] = ((32'(j + 1) & msk) == 32'd0);
      lk_r[j]    = dir ? link_q[j] : link_q[N-2-j];
    end
    for (int i = 0; i < N; i++) begin
      m_r[i] = dir ? m_tag[i] : m_tag[N-1-i];
      d_r[i] = dir ? d_tag[i] : d_tag[N-1-i];
    end
  end

  always_comb begin
    c   = inj;
    a_r = '0;
    for (int i = 0; i < N; i++) begin
      if (blk[i]) c = 1'b0;
      case (mode)
        MD_NEIGH: begin
          a_r[i] = c;
          c      = m_r[i];
        end
        MD_REMOTE: begin
          a_r[i] = c & d_r[i];
          c      = m_r[i] | (c & ~d_r[i]);
        end
        MD_BETW: begin
          a_r[i] = c | (incl_src & m_r[i]);
          c      = c ^ m_r[i];
        end
        MD_END: begin
          a_r[i] = c | (incl_src & m_r[i]);
          c      = c | m_r[i];
        end
        default: begin
          a_r[i] = 1'b0;
          c      = 1'b0;
        end
      endcase
    end
    tail = c;
  end

  always_comb begin
    a_nxt = '0;
    if (mode == MD_MATCH)     a_nxt = m_tag;
    else if (mode == MD_MISS) a_nxt = ~m_tag;
    else if (mode <= MD_END)
      for (int i = 0; i < N; i++) a_nxt[i] = dir ? a_r[i] : a_r[N-1-i];
  end

  assign lp_out = ~dir & tail;
  assign rp_out = dir & tail;

  always_ff @(posedge clk) begin
    if (!rst_n)        link_q <= '0;
    else if (seg_cmd)  link_q <= seg_pat;
    else if (link_wr)  link_q <= link_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     act <= '0;
    else if (fire)  act <= a_nxt;
  end
endmodule

// File: rtl/act_spread_chk.sv
module act_spread_chk #(
  parameter int N = 16,
  localparam int LGW = $clog2(N) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fire,
  input logic [2:0]     mode,
  input logic           dir,
  input logic [N-1:0]   m_tag,
  input logic [N-1:0]   act,
  input logic           lp_out,
  input logic           rp_out,
  input logic           seg_cmd,
  input logic [LGW-1:0] seg_lg,
  input logic [N-2:0]   link_q
);
  AST_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(act)); // R2
  AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == 3'd0 |=> act == $past(m_tag)); // R3
  AST_MISS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == 3'd1 |=> act == ~$past(m_tag)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode >= 3'd6 |=> act == '0); // R11
  AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd1 || mode >= 3'd6) |-> !lp_out && !rp_out); // R10
  AST_PORT_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_out && rp_out)); // R10
  AST_SEG_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    seg_cmd && seg_lg == '0 |=> &link_q); // R9
  AST_NEIGH_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode == 3'd2 && dir && link_q[0] |=> !act[1]); // R8
endmodule

bind act_spread act_spread_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .mode(mode), .dir(dir),
  .m_tag(m_tag), .act(act), .lp_out(lp_out), .rp_out(rp_out),
  .seg_cmd(seg_cmd), .seg_lg(seg_lg), .link_q(link_q)
);

// File: tb/sim_act_spread.sv
`timescale 1ns/1ps
module sim_act_spread;
  localparam int N = 8;
  localparam int LGW = $clog2(N) + 1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] m_tag = '0, d_tag = '0;
  logic [2:0] mode = '0;
  logic dir = 0, incl_src = 0, lp_in = 0, rp_in = 0, fire = 0;
  logic link_wr = 0, seg_cmd = 0;
  logic [N-2:0] link_wdata = '0;
  logic [LGW-1:0] seg_lg = '0;
  logic [N-1:0] act;
  logic lp_out, rp_out, lp_s, rp_s;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  act_spread #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .m_tag(m_tag), .d_tag(d_tag), .mode(mode),
    .dir(dir), .incl_src(incl_src), .lp_in(lp_in), .rp_in(rp_in),
    .fire(fire), .link_wr(link_wr), .link_wdata(link_wdata),
    .seg_cmd(seg_cmd), .seg_lg(seg_lg), .act(act), .lp_out(lp_out),
    .rp_out(rp_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic shot(input logic [2:0] md, input logic [N-1:0] m, input logic [N-1:0] d,
                      input logic dr, input logic inc, input logic li, input logic ri);
    @(negedge clk);
    mode = md; m_tag = m; d_tag = d; dir = dr; incl_src = inc;
    lp_in = li; rp_in = ri; fire = 1;
    #1 lp_s = lp_out; rp_s = rp_out;
    @(negedge clk);
    fire = 0; lp_in = 0; rp_in = 0;
  endtask

  task automatic links(input logic wr, input logic [N-2:0] wd, input logic sc, input logic [LGW-1:0] lg);
    @(negedge clk);
    link_wr = wr; link_wdata = wd; seg_cmd = sc; seg_lg = lg;
    @(negedge clk);
    link_wr = 0; seg_cmd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_basic();
    shot(3'd0, 8'b1010_0110, '0, 1, 0, 0, 0);
    chk("R3 match", act, 8'b1010_0110);
    chk("R10 idle lp", lp_s, 0); chk("R10 idle rp", rp_s, 0);
    shot(3'd1, 8'b1010_0110, '0, 1, 0, 0, 0);
    chk("R3 mismatch", act, 8'b0101_1001);
    @(negedge clk); m_tag = 8'hFF; mode = 3'd0;
    repeat (3) @(negedge clk);
    chk("R2 hold", act, 8'b0101_1001);
  endtask

  task automatic t_neigh();
    shot(3'd2, 8'b0000_0101, '0, 1, 0, 0, 0);
    chk("R4 right", act, 8'b0000_1010);
    chk("R10 rp neigh", rp_s, 0);
    shot(3'd2, 8'b0000_0101, '0, 1, 0, 1, 0);
    chk("R4 right inject", act, 8'b0000_1011);
    shot(3'd2, 8'b0000_0101, '0, 0, 0, 0, 0);
    chk("R4 left", act, 8'b0000_0010);
    chk("R10 lp neigh", lp_s, 1); chk("R10 rp other", rp_s, 0);
    shot(3'd2, 8'b0000_0101, '0, 0, 0, 0, 1);
    chk("R4 left inject", act, 8'b1000_0010);
  endtask

  task automatic t_remote();
    shot(3'd3, 8'b0000_0010, 8'b0010_1000, 1, 0, 0, 0);
    chk("R5 right first dest", act, 8'b0000_1000);
    chk("R10 rp absorbed", rp_s, 0);
    shot(3'd3, 8'b0001_0010, 8'b0010_1000, 1, 0, 0, 0);
    chk("R5 two sources", act, 8'b0010_1000);
    shot(3'd3, 8'b0100_0000, 8'b0001_0100, 0, 0, 0, 0);
    chk("R5 left", act, 8'b0001_0000);
    shot(3'd3, 8'b0000_0000, 8'b0000_1000, 1, 0, 1, 0);
    chk("R5 port source", act, 8'b0000_1000);
    shot(3'd3, 8'b0010_0000, 8'b0000_0000, 1, 0, 0, 0);
    chk("R5 no dest", act, 8'b0000_0000);
    chk("R10 rp escape", rp_s, 1);
  endtask

  task automatic t_between();
    shot(3'd4, 8'b0001_0010, '0, 1, 0, 0, 0);
    chk("R6 right", act, 8'b0001_1100);
    shot(3'd4, 8'b0001_0010, '0, 1, 1, 0, 0);
    chk("R6 right incl", act, 8'b0001_1110);
    shot(3'd4, 8'b0110_0101, '0, 1, 0, 0, 0);
    chk("R6 two pairs", act, 8'b0100_0110);
    shot(3'd4, 8'b0001_0010, '0, 0, 0, 0, 0);
    chk("R6 left", act, 8'b0000_1110);
    shot(3'd4, 8'b0001_0010, '0, 0, 1, 0, 0);
    chk("R6 left incl", act, 8'b0001_1110);
    shot(3'd4, 8'b0010_0000, '0, 1, 0, 0, 0);
    chk("R6 unclosed", act, 8'b1100_0000);
    chk("R10 rp open run", rp_s, 1);
  endtask

  task automatic t_end();
    shot(3'd5, 8'b0000_1000, '0, 1, 0, 0, 0);
    chk("R7 right", act, 8'b1111_0000);
    chk("R10 rp end", rp_s, 1);
    shot(3'd5, 8'b0000_1000, '0, 1, 1, 0, 0);
    chk("R7 right incl", act, 8'b1111_1000);
    shot(3'd5, 8'b0000_1000, '0, 0, 0, 0, 0);
    chk("R7 left", act, 8'b0000_0111);
    chk("R10 lp end", lp_s, 1); chk("R10 rp quiet", rp_s, 0);
  endtask

  task automatic t_links();
    links(1, 7'b001_0000, 0, '0);
    shot(3'd5, 8'b0000_0100, '0, 1, 0, 0, 0);
    chk("R8 end cut", act, 8'b0001_1000);
    chk("R8 port cut", rp_s, 0);
    shot(3'd2, 8'b0001_0000, '0, 1, 0, 0, 0);
    chk("R8 neigh right cut", act, 8'b0000_0000);
    shot(3'd2, 8'b0010_0000, '0, 0, 0, 0, 0);
    chk("R8 neigh left cut", act, 8'b0000_0000);
    shot(3'd2, 8'b0000_1000, '0, 1, 0, 0, 0);
    chk("R8 neigh same seg", act, 8'b0001_0000);
  endtask

  task automatic t_seg();
    links(0, '0, 1, 4'd1);
    shot(3'd5, 8'b0001_0001, '0, 1, 0, 0, 0);
    chk("R9 seg2", act, 8'b0010_0010);
    links(0, '0, 1, 4'd2);
    shot(3'd5, 8'b0000_0010, '0, 1, 0, 0, 0);
    chk("R9 seg4", act, 8'b0000_1100);
    links(0, '0, 1, 4'd3);
    shot(3'd5, 8'b0000_0010, '0, 1, 0, 0, 0);
    chk("R9 seg8", act, 8'b1111_1100);
    links(1, 7'b000_0000, 1, 4'd0);
    shot(3'd5, 8'b0000_0001, '0, 1, 0, 0, 0);
    chk("R9 seg1 priority", act, 8'b0000_0000);
    shot(3'd5, 8'b0000_0000, '0, 1, 0, 1, 0);
    chk("R9 seg1 inject", act, 8'b0000_0001);
  endtask

  task automatic t_rsvd();
    shot(3'd0, 8'hA5, '0, 1, 0, 0, 0);
    shot(3'd6, 8'hA5, 8'hFF, 1, 1, 1, 1);
    chk("R11 mode6", act, 8'h00);
    chk("R10 mode6 ports", {lp_s, rp_s}, 2'b00);
    shot(3'd0, 8'h3C, '0, 1, 0, 0, 0);
    shot(3'd7, 8'h3C, '0, 0, 1, 1, 1);
    chk("R11 mode7", act, 8'h00);
  endtask

  task automatic t_reset();
    shot(3'd0, 8'h5A, '0, 1, 0, 0, 0);
    do_reset();
    chk("R1 act cleared", act, 8'h00);
    shot(3'd5, 8'b0000_0001, '0, 1, 0, 0, 0);
    chk("R1 links closed", act, 8'b1111_1110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset", act, 8'h00);
    t_basic(); t_neigh(); t_remote(); t_between(); t_end();
    t_links(); t_seg(); t_rsvd(); t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog got=%0d exp=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule